// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the byte a host sees when it reads a flash device. The byte comes from one of three places. While an internal program or erase runs, it is a status word. In identification mode it is an identification or protection code. Otherwise it is the array contents supplied on an external port. The status word carries several indicators at once, on separate bits:
- a data-polling bit that reflects the operation type;
- a bit that flips on every read while the operation is active;
- a bit that flips only on reads aimed at sectors chosen for erase;
- a bit that reports whether the sector-erase accept window has closed.

The block also drives an active-low busy indication.

A read is a one-cycle strobe carrying a sector index and the two lowest address bits. The byte appears on `rd_data` one clock later and holds until the next strobe. The controller that sequences the operation supplies the operation state. This includes a level that stays high for the whole operation, including any suspension. The block detects the start of a new operation on that level's rising edge and clears both flip bits there.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rd_data` is 00h and `busy_n` is 1.
- R2: `busy_n` is 0 exactly one cycle after a cycle in which `op_busy` is 1 and the operation is not a suspended sector erase, and it is 1 otherwise.
- R3: While a program (`op_kind` = 0) is active, bit 7 of a read returns the complement of `prog_bit7`. Once `op_busy` falls, reads return the array byte, so bit 7 returns its true value.
- R4: While an erase (`op_kind` 1 = sector erase, 2 or 3 = chip erase) is active, bit 7 reads 0. In every status byte, bits 5, 4, 1 and 0 read 0.
- R5: Bit 6 of a status byte reads 0 on the first read after `op_busy` rises. It inverts after each read made while the operation is active, and it holds during a suspension.
- R6: Bit 2 of a status byte during an erase reads 0 first after the start. It inverts after each read whose sector is selected for erase, whether active or suspended, and it holds on other reads. Chip erase selects every sector. During a program, bit 2 reads 0.
- R7: Bit 3 of a status byte equals `window_closed` while an erase is active, and reads 0 during a program or a suspension.
- R8: `suspended` takes effect only during a sector erase. While suspended, reads of erase-selected sectors return a status byte with bit 7 = 1, and reads of other sectors return `array_data`. During a chip erase or a program, `suspended` changes nothing.
- R9: With `op_busy` low and `autosel` low, a read returns `array_data`.
- R10: With `op_busy` low and `autosel` high, a read returns a byte selected by `rd_sel`: 0 gives 04h, 1 gives D5h, 2 gives 01h if the sector's group (sector index / `GROUP_SECT`) is protected in `prot_mask` and 00h if not, and 3 gives 00h.
- R11: `rd_data` does not change in a cycle that follows a cycle without `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_busy | input | 1 | Embedded operation in progress (held through suspension) |
| op_kind | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| erase_mask | input | NSECT | Sectors selected for sector erase |
| window_closed | input | 1 | Sector-erase accept window has closed |
| suspended | input | 1 | Erase suspension requested |
| autosel | input | 1 | Identification mode |
| prot_mask | input | NSECT/GROUP_SECT | Protected sector groups |
| rd_stb | input | 1 | Read strobe |
| rd_sect | input | $clog2(NSECT) | Sector index of the read address |
| rd_sel | input | 2 | Two lowest read address bits |
| array_data | input | 8 | Array contents at the read address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| busy_n | output | 1 | Low while an operation is actively running |

## Verification
The bench builds the block with eight sectors in groups of two, so four protection groups. This configuration lets it sweep every sector and every low-address code in identification mode against a mixed protection pattern. It also runs sector erases with several erase masks, so that each sector is seen both in and out of the erase set. The bench interleaves active and suspended phases to show that the two flip bits advance on different conditions. It then runs a chip erase with suspension requested, showing that the request is ignored there.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [1:0] {
        OPK_PROGRAM    = 2'd0,
        OPK_SECT_ERASE = 2'd1,
        OPK_CHIP_ERASE = 2'd2,
        OPK_CHIP_ALT   = 2'd3
    } op_kind_e;

    // status bit positions
    localparam int SB_POLL   = 7;
    localparam int SB_TOGGLE = 6;
    localparam int SB_WINDOW = 3;
    localparam int SB_SECTOG = 2;

    // autoselect low-address selectors
    localparam logic [1:0] AS_MFR  = 2'd0;
    localparam logic [1:0] AS_DEV  = 2'd1;
    localparam logic [1:0] AS_PROT = 2'd2;

    typedef struct packed {
        logic [7:0] rd_data;
        logic       busy_n;
        logic       busy_prev;
        logic       tog_any;
        logic       tog_sect;
    } stat_state_t;

endpackage

// File: rtl/fsg_sector_lookup.sv
module fsg_sector_lookup #(
    parameter int NSECT      = 16,
    parameter int GROUP_SECT = 2,
    localparam int SIDX_W    = $clog2(NSECT),
    localparam int NGRP      = NSECT / GROUP_SECT
) (
    input  logic [SIDX_W-1:0] sect,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic [NGRP-1:0]   prot_mask,
    input  logic              all_sect,
    output logic              in_erase,
    output logic              grp_prot
);

    logic [NSECT-1:0] sect_prot;

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign sect_prot[s] = prot_mask[s / GROUP_SECT];
    end

    assign in_erase = all_sect | erase_mask[sect];
    assign grp_prot = sect_prot[sect];

endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux
    import flash_status_pkg::*;
#(
    parameter logic [7:0] MFR_CODE = 8'h04,
    parameter logic [7:0] DEV_CODE = 8'hD5
) (
    input  logic       use_status,
    input  logic       use_ident,
    input  logic [7:0] status_byte,
    input  logic [7:0] array_data,
    input  logic [1:0] sel,
    input  logic       grp_prot,
    output logic [7:0] byte_out
);

    logic [7:0] ident_byte;

    always_comb begin
        case (sel)
            AS_MFR:  ident_byte = MFR_CODE;
            AS_DEV:  ident_byte = DEV_CODE;
            AS_PROT: ident_byte = {7'd0, grp_prot};
            default: ident_byte = 8'h00;
        endcase
    end

    always_comb begin
        if (use_status)     byte_out = status_byte;
        else if (use_ident) byte_out = ident_byte;
        else                byte_out = array_data;
    end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int         NSECT      = 16,
    parameter int         GROUP_SECT = 2,
    parameter logic [7:0] MFR_CODE   = 8'h04,
    parameter logic [7:0] DEV_CODE   = 8'hD5,
    localparam int        SIDX_W     = $clog2(NSECT),
    localparam int        NGRP       = NSECT / GROUP_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_busy,
    input  logic [1:0]        op_kind,
    input  logic              prog_bit7,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic              window_closed,
    input  logic              suspended,
    input  logic              autosel,
    input  logic [NGRP-1:0]   prot_mask,
    input  logic              rd_stb,
    input  logic [SIDX_W-1:0] rd_sect,
    input  logic [1:0]        rd_sel,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data,
    output logic              busy_n
);

    stat_state_t st_q, st_d;

    logic       is_prog, is_chip, is_erase;
    logic       eff_susp, running, op_start;
    logic       in_erase, grp_prot;
    logic       tog_any_base, tog_sect_base;
    logic       use_status, use_ident;
    logic [7:0] status_byte, mux_byte;

    assign is_prog  = (op_kind == OPK_PROGRAM);
    assign is_chip  = op_kind[1];
    assign is_erase = !is_prog;
    assign eff_susp = suspended && (op_kind == OPK_SECT_ERASE);
    assign running  = op_busy && !eff_susp;
    assign op_start = op_busy && !st_q.busy_prev;

    fsg_sector_lookup #(
        .NSECT      (NSECT),
        .GROUP_SECT (GROUP_SECT)
    ) u_lookup (
        .sect       (rd_sect),
        .erase_mask (erase_mask),
        .prot_mask  (prot_mask),
        .all_sect   (is_chip),
        .in_erase   (in_erase),
        .grp_prot   (grp_prot)
    );

    assign tog_any_base  = op_start ? 1'b0 : st_q.tog_any;
    assign tog_sect_base = op_start ? 1'b0 : st_q.tog_sect;

    always_comb begin
        status_byte = 8'h00;
        if (running)
            status_byte[SB_POLL] = is_prog ? !prog_bit7 : 1'b0;
        else
            status_byte[SB_POLL] = 1'b1;
        status_byte[SB_TOGGLE] = tog_any_base;
        status_byte[SB_WINDOW] = running && is_erase && window_closed;
        status_byte[SB_SECTOG] = is_erase && tog_sect_base;
    end

    assign use_status = op_busy && (running || in_erase);
    assign use_ident  = !op_busy && autosel;

    fsg_read_mux #(
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_mux (
        .use_status  (use_status),
        .use_ident   (use_ident),
        .status_byte (status_byte),
        .array_data  (array_data),
        .sel         (rd_sel),
        .grp_prot    (grp_prot),
        .byte_out    (mux_byte)
    );

    always_comb begin
        st_d           = st_q;
        st_d.busy_prev = op_busy;
        st_d.busy_n    = !running;
        st_d.tog_any   = tog_any_base ^ (rd_stb && running);
        st_d.tog_sect  = tog_sect_base ^ (rd_stb && op_busy && is_erase && in_erase);
        if (rd_stb)
            st_d.rd_data = mux_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rd_data   <= 8'h00;
            st_q.busy_n    <= 1'b1;
            st_q.busy_prev <= 1'b0;
            st_q.tog_any   <= 1'b0;
            st_q.tog_sect  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;
    assign busy_n  = st_q.busy_n;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter logic [7:0] MFR_CODE = 8'h04,
    parameter logic [7:0] DEV_CODE = 8'hD5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       op_busy,
    input logic [1:0] op_kind,
    input logic       prog_bit7,
    input logic       suspended,
    input logic       autosel,
    input logic       rd_stb,
    input logic [1:0] rd_sel,
    input logic [7:0] array_data,
    input logic [7:0] rd_data,
    input logic       busy_n
);

    AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> busy_n == !$past(op_busy && !(suspended && op_kind == 2'd1))); // R2

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_stb && op_busy && op_kind == 2'd0) |-> rd_data[7] == !$past(prog_bit7)); // R3

    AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_stb && op_busy && !suspended) |-> (rd_data[5:4] == 2'b00 && rd_data[1:0] == 2'b00)); // R4

    AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_stb && !op_busy && !autosel) |-> rd_data == $past(array_data)); // R9

    AST_IDENT_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_stb && !op_busy && autosel && rd_sel == 2'd1) |-> rd_data == DEV_CODE); // R10

    AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_stb && !op_busy && autosel && rd_sel == 2'd0) |-> rd_data == MFR_CODE); // R10

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !rd_stb) |-> $stable(rd_data)); // R11

endmodule

bind flash_status_gen fsg_checker #(
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_busy    (op_busy),
    .op_kind    (op_kind),
    .prog_bit7  (prog_bit7),
    .suspended  (suspended),
    .autosel    (autosel),
    .rd_stb     (rd_stb),
    .rd_sel     (rd_sel),
    .array_data (array_data),
    .rd_data    (rd_data),
    .busy_n     (busy_n)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

    localparam int NSECT = 8;
    localparam int GSZ   = 2;
    localparam int SW    = 3;
    localparam int NG    = NSECT / GSZ;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_busy = 1'b0;
    logic [1:0]      op_kind = 2'd0;
    logic            prog_bit7 = 1'b0;
    logic [NSECT-1:0] erase_mask = '0;
    logic            window_closed = 1'b0;
    logic            suspended = 1'b0;
    logic            autosel = 1'b0;
    logic [NG-1:0]   prot_mask = '0;
    logic            rd_stb = 1'b0;
    logic [SW-1:0]   rd_sect = '0;
    logic [1:0]      rd_sel = '0;
    logic [7:0]      array_data = '0;
    logic [7:0]      rd_data;
    logic            busy_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit m_t6 = 0;
    bit m_t2 = 0;

    always #5 clk = ~clk;

    flash_status_gen #(.NSECT(NSECT), .GROUP_SECT(GSZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_kind(op_kind),
        .prog_bit7(prog_bit7), .erase_mask(erase_mask), .window_closed(window_closed),
        .suspended(suspended), .autosel(autosel), .prot_mask(prot_mask),
        .rd_stb(rd_stb), .rd_sect(rd_sect), .rd_sel(rd_sel),
        .array_data(array_data), .rd_data(rd_data), .busy_n(busy_n)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] arr_of(input int s, input int l);
        return 8'(((s * 4 + l) * 29 + 7) ^ 8'h5A);
    endfunction

    // begin an operation: bench model clears its flip bits on the rising edge of op_busy
    task automatic start_op(input logic [1:0] kind);
        op_kind = kind;
        op_busy = 1'b1;
        m_t6 = 0;
        m_t2 = 0;
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input int s, input int l);
        logic [7:0] exp;
        bit chip, ers, esusp, act, in_e;
        chip  = op_kind[1];
        ers   = (op_kind != 2'd0);
        esusp = suspended && (op_kind == 2'd1);
        act   = op_busy && !esusp;
        in_e  = chip || erase_mask[s];
        if (op_busy && (act || in_e)) begin
            exp = 8'h00;
            exp[7] = act ? ((op_kind == 2'd0) ? !prog_bit7 : 1'b0) : 1'b1;
            exp[6] = m_t6;
            exp[3] = act && ers && window_closed;
            exp[2] = ers && m_t2;
            if (act) m_t6 = !m_t6;
            if (ers && in_e) m_t2 = !m_t2;
        end else if (!op_busy && autosel) begin
            case (l)
                0: exp = 8'h04;
                1: exp = 8'hD5;
                2: exp = {7'd0, prot_mask[s / GSZ]};
                default: exp = 8'h00;
            endcase
        end else begin
            exp = arr_of(s, l);
        end
        rd_sect    = SW'(s);
        rd_sel     = 2'(l);
        array_data = arr_of(s, l);
        rd_stb     = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 busy_n", {7'd0, busy_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: idle array reads across all sectors and selectors
        for (int s = 0; s < NSECT; s++)
            for (int l = 0; l < 4; l++)
                read_chk("R9 idle array", s, l);

        // R11: data holds while no strobe, even when array changes
        held = rd_data;
        array_data = ~held;
        repeat (3) @(negedge clk);
        check("R11 hold", rd_data, held);

        // R10: identification sweep with mixed protection
        autosel   = 1'b1;
        prot_mask = 4'b1010;
        for (int s = 0; s < NSECT; s++)
            for (int l = 0; l < 4; l++)
                read_chk("R10 ident", s, l);
        prot_mask = 4'b0101;
        for (int s = 0; s < NSECT; s++)
            read_chk("R10 prot", s, 2);
        autosel = 1'b0;

        // R3/R5/R2: programs with both data bit values, suspend ignored
        for (int p = 0; p < 4; p++) begin
            prog_bit7 = p[0];
            suspended = p[1];
            window_closed = 1'b1;
            start_op(2'd0);
            check("R2 busy prog", {7'd0, busy_n}, 8'h00);
            for (int k = 0; k < 5; k++)
                read_chk("R3 R5 R7 R8 prog status", (k * 3) % NSECT, k % 4);
            op_busy = 1'b0;
            suspended = 1'b0;
            @(negedge clk);
            check("R2 busy done", {7'd0, busy_n}, 8'h01);
            read_chk("R3 after program", p, 1);
        end

        // R4/R6/R7/R8: sector erase with suspend/resume across masks
        for (int m = 0; m < 3; m++) begin
            erase_mask = (m == 0) ? 8'b0000_0001 : (m == 1) ? 8'b1010_0101 : 8'b0111_1110;
            window_closed = 1'b0;
            start_op(2'd1);
            check("R2 busy erase", {7'd0, busy_n}, 8'h00);
            for (int s = 0; s < NSECT; s++) read_chk("R4 R5 R6 R7 erase", s, 0);
            window_closed = 1'b1;
            for (int s = 0; s < NSECT; s++) read_chk("R6 R7 window", s, 3);
            suspended = 1'b1;
            @(negedge clk);
            check("R2 busy suspended", {7'd0, busy_n}, 8'h01);
            for (int s = 0; s < NSECT; s++) read_chk("R5 R6 R7 R8 suspended", s, 1);
            suspended = 1'b0;
            @(negedge clk);
            check("R2 busy resumed", {7'd0, busy_n}, 8'h00);
            for (int s = 0; s < NSECT; s++) read_chk("R5 R6 resumed", s, 2);
            op_busy = 1'b0;
            @(negedge clk);
            read_chk("R9 after erase", m, 0);
        end

        // R8: chip erase ignores suspension, all sectors selected
        erase_mask = '0;
        suspended  = 1'b1;
        window_closed = 1'b1;
        start_op(2'd2);
        check("R8 chip busy", {7'd0, busy_n}, 8'h00);
        for (int s = 0; s < NSECT; s++) read_chk("R4 R6 R8 chip erase", s, 0);
        op_kind = 2'd3;
        for (int s = 0; s < NSECT; s++) read_chk("R4 R6 chip alt", s, 1);
        op_busy = 1'b0;
        suspended = 1'b0;
        @(negedge clk);
        check("R2 busy idle", {7'd0, busy_n}, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule